// File: doc/BRIEF.md
# Windowed Layer Alpha Blender

This block places one layer of an on-screen display over the colour beneath it. For each pixel slot it receives the raster counter position, one decoded layer pixel with 8-bit alpha, red, green and blue channels, and the colour of the background or of the layer below. It produces the composited RGB value. The layer covers only a rectangle set by inclusive start and stop counter positions on each axis. These positions are in counter units: the screen coordinate plus one plus the accumulated back porch. Outside that rectangle, or whenever the layer is switched off, the lower colour goes through unchanged.

The layer and lower colours are weighted by two blend factors. Each factor is chosen by a 3-bit code: the upper factor uses either the constant alpha or the pixel alpha scaled by the constant alpha, and the lower factor uses one minus one of those two. A constant alpha of 255 means full opacity. The datapath is a two-stage pipeline that accepts one pixel per clock and delivers each result exactly two clocks after its inputs are sampled.

Top module: `layer_win_blend`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the clock edge after any cycle in which it was asserted, `out_rgb` is zero.
- R2: The result for inputs sampled at a rising edge appears on `out_rgb` after the second rising edge that follows and holds for one clock. A new pixel is accepted every clock.
- R3: When `lay_en` is 0, `out_rgb` equals the `low_rgb` value sampled two edges earlier, whatever the layer pixel, window and factor inputs are.
- R4: The layer is in the window horizontally when `win_x0 <= pos_x <= win_x1`; both bounds are inclusive. Any position outside this range passes `low_rgb` through unchanged.
- R5: The layer is in the window vertically when `win_y0 <= pos_y <= win_y1`; both bounds are inclusive. Any position outside this range passes `low_rgb` through unchanged.
- R6: The scaled alpha is PA = floor((A*CA + 127)/255), where A is `lay_argb[31:24]` and CA is `const_alpha`. Upper factor code 4 selects F1 = CA, and code 6 selects F1 = PA. PA never exceeds CA.
- R7: Lower factor code 5 selects F2 = 255 - CA, and code 7 selects F2 = 255 - PA.
- R8: Inside the window with the layer on, each channel is min(255, floor((F1*C + F2*L + 127)/255)). C is the layer channel and L the lower channel. Red is in bits 23:16, green in 15:8 and blue in 7:0 of both the layer pixel and `low_rgb`.
- R9: Any upper code other than 6 acts as code 4, and any lower code other than 7 acts as code 5.
- R10: With CA = 255, upper code 4 and lower code 5, a pixel in the window shows the layer colour exactly. With CA = 0 and any codes other than 6 and 7, it shows the lower colour exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pos_x | input | 12 | Horizontal raster counter position |
| pos_y | input | 11 | Vertical raster counter position |
| lay_en | input | 1 | Layer enable |
| lay_argb | input | 32 | Decoded layer pixel: alpha 31:24, red 23:16, green 15:8, blue 7:0 |
| low_rgb | input | 24 | Lower colour: red 23:16, green 15:8, blue 7:0 |
| win_x0 | input | 12 | First horizontal counter position inside the window |
| win_x1 | input | 12 | Last horizontal counter position inside the window |
| win_y0 | input | 11 | First vertical counter position inside the window |
| win_y1 | input | 11 | Last vertical counter position inside the window |
| const_alpha | input | 8 | Constant alpha, 255 meaning 1.0 |
| f1_code | input | 3 | Upper blend factor select |
| f2_code | input | 3 | Lower blend factor select |
| out_rgb | output | 24 | Blended colour, two clocks after its inputs |

## Verification
The bound checker watches several things on every cycle. It checks that the output is cleared after reset and that a disabled layer gives back the lower colour two cycles later. It checks that a window miss in the first stage turns into a pass-through in the second. It also checks that the scaled alpha never exceeds the constant alpha, and that the two extreme constant alphas give the exact layer or lower colour. The per-channel arithmetic cannot be checked that way: rounding, saturation when the two factors sum above 255, and the handling of unused factor codes are shown only by the bench. The bench also covers the exact inclusive edges of the window on both axes. It sweeps every pair of factor codes across a grid of pixel and constant alpha values, and it walks positions across the window edges.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

  typedef logic [2:0] fcode_t;

  // upper factor selections
  localparam fcode_t F1_CONST      = 3'd4;
  localparam fcode_t F1_PIX_CONST  = 3'd6;
  // lower factor selections
  localparam fcode_t F2_INV_CONST     = 3'd5;
  localparam fcode_t F2_INV_PIX_CONST = 3'd7;

  localparam int NUM_CH = 3;

endpackage

// File: rtl/lwb_win_hit.sv
module lwb_win_hit #(
  parameter int XW = 12,
  parameter int YW = 11
) (
  input  logic          en,
  input  logic [XW-1:0] px,
  input  logic [YW-1:0] py,
  input  logic [XW-1:0] x0,
  input  logic [XW-1:0] x1,
  input  logic [YW-1:0] y0,
  input  logic [YW-1:0] y1,
  output logic          hit
);

  logic in_x;
  logic in_y;

  // bounds are inclusive on both ends
  always_comb begin
    in_x = (px >= x0) && (px <= x1);
    in_y = (py >= y0) && (py <= y1);
    hit  = en && in_x && in_y;
  end

endmodule

// File: rtl/lwb_alpha_mul.sv
module lwb_alpha_mul #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] ca,
  output logic [CW-1:0] pa
);

  localparam int PW = 2 * CW;
  localparam logic [CW-1:0] FULL = '1;
  localparam logic [CW-1:0] HALF = FULL >> 1;

  logic [PW-1:0] prod;

  // rounded a*ca/FULL; fits since FULL^2 + HALF < 2^PW
  always_comb begin
    prod = PW'(a) * PW'(ca) + PW'(HALF);
    pa   = CW'(prod / PW'(FULL));
  end

endmodule

// File: rtl/lwb_factor_sel.sv
module lwb_factor_sel
  import lwb_pkg::*;
#(
  parameter int CW = 8
) (
  input  fcode_t        code1,
  input  fcode_t        code2,
  input  logic [CW-1:0] pa,
  input  logic [CW-1:0] ca,
  output logic [CW-1:0] f1,
  output logic [CW-1:0] f2
);

  localparam logic [CW-1:0] FULL = '1;

  always_comb begin
    case (code1)
      F1_PIX_CONST: f1 = pa;
      F1_CONST:     f1 = ca;
      default:      f1 = ca;
    endcase
    case (code2)
      F2_INV_PIX_CONST: f2 = FULL - pa;
      F2_INV_CONST:     f2 = FULL - ca;
      default:          f2 = FULL - ca;
    endcase
  end

endmodule

// File: rtl/lwb_chan_mix.sv
module lwb_chan_mix #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] f1,
  input  logic [CW-1:0] f2,
  input  logic [CW-1:0] c,
  input  logic [CW-1:0] l,
  output logic [CW-1:0] y
);

  localparam int PW = 2 * CW + 1;
  localparam logic [CW-1:0] FULL = '1;
  localparam logic [CW-1:0] HALF = FULL >> 1;

  logic [PW-1:0] acc;
  logic [PW-1:0] quo;

  always_comb begin
    acc = PW'(f1) * PW'(c) + PW'(f2) * PW'(l) + PW'(HALF);
    quo = acc / PW'(FULL);
    // factors may sum above FULL, so clamp
    y   = (quo > PW'(FULL)) ? FULL : quo[CW-1:0];
  end

endmodule

// File: rtl/layer_win_blend.sv
module layer_win_blend
  import lwb_pkg::*;
#(
  parameter int CW = 8,
  parameter int XW = 12,
  parameter int YW = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [XW-1:0]        pos_x,
  input  logic [YW-1:0]        pos_y,
  input  logic                 lay_en,
  input  logic [4*CW-1:0]      lay_argb,
  input  logic [NUM_CH*CW-1:0] low_rgb,
  input  logic [XW-1:0]        win_x0,
  input  logic [XW-1:0]        win_x1,
  input  logic [YW-1:0]        win_y0,
  input  logic [YW-1:0]        win_y1,
  input  logic [CW-1:0]        const_alpha,
  input  logic [2:0]           f1_code,
  input  logic [2:0]           f2_code,
  output logic [NUM_CH*CW-1:0] out_rgb
);

  localparam int RGBW = NUM_CH * CW;

  // ---------------- stage 0: combinational front end ----------------
  logic          hit_c;
  logic [CW-1:0] pa_c;

  lwb_win_hit #(.XW(XW), .YW(YW)) u_win (
    .en  (lay_en),
    .px  (pos_x),
    .py  (pos_y),
    .x0  (win_x0),
    .x1  (win_x1),
    .y0  (win_y0),
    .y1  (win_y1),
    .hit (hit_c)
  );

  lwb_alpha_mul #(.CW(CW)) u_amul (
    .a  (lay_argb[4*CW-1 -: CW]),
    .ca (const_alpha),
    .pa (pa_c)
  );

  // ---------------- stage 1 registers ----------------
  logic            s1_hit;
  logic [CW-1:0]   s1_pa;
  logic [CW-1:0]   s1_ca;
  fcode_t          s1_f1code;
  fcode_t          s1_f2code;
  logic [RGBW-1:0] s1_col;
  logic [RGBW-1:0] s1_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_hit    <= 1'b0;
      s1_pa     <= '0;
      s1_ca     <= '0;
      s1_f1code <= '0;
      s1_f2code <= '0;
      s1_col    <= '0;
      s1_low    <= '0;
    end else begin
      s1_hit    <= hit_c;
      s1_pa     <= pa_c;
      s1_ca     <= const_alpha;
      s1_f1code <= f1_code;
      s1_f2code <= f2_code;
      s1_col    <= lay_argb[RGBW-1:0];
      s1_low    <= low_rgb;
    end
  end

  // ---------------- stage 1 combinational: factors and mixing ----------------
  logic [CW-1:0]   f1_w;
  logic [CW-1:0]   f2_w;
  logic [RGBW-1:0] mix_w;

  lwb_factor_sel #(.CW(CW)) u_fsel (
    .code1 (s1_f1code),
    .code2 (s1_f2code),
    .pa    (s1_pa),
    .ca    (s1_ca),
    .f1    (f1_w),
    .f2    (f2_w)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    lwb_chan_mix #(.CW(CW)) u_mix (
      .f1 (f1_w),
      .f2 (f2_w),
      .c  (s1_col[ch*CW +: CW]),
      .l  (s1_low[ch*CW +: CW]),
      .y  (mix_w[ch*CW +: CW])
    );
  end

  // ---------------- stage 2: registered output ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_rgb <= '0;
    end else begin
      out_rgb <= s1_hit ? mix_w : s1_low;
    end
  end

endmodule

// File: rtl/lwb_chk.sv
module lwb_chk #(
  parameter int CW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lay_en,
  input logic [3*CW-1:0]   low_rgb,
  input logic [3*CW-1:0]   out_rgb,
  input logic              s1_hit,
  input logic [CW-1:0]     s1_pa,
  input logic [CW-1:0]     s1_ca,
  input logic [2:0]        s1_f1code,
  input logic [2:0]        s1_f2code,
  input logic [3*CW-1:0]   s1_col,
  input logic [3*CW-1:0]   s1_low
);

  localparam logic [CW-1:0] FULL = '1;

  // counts non-reset edges so that $past never reaches before reset
  logic [1:0] age;
  logic       rdy;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assign rdy = (age == 2'd2);

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (out_rgb == '0))
    else $error("rst_clear_chk");

  // R3
  off_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy && $past(!lay_en, 2)) |-> (out_rgb == $past(low_rgb, 2)))
    else $error("off_pass_chk");

  // R4 R5
  miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy && !$past(s1_hit)) |-> (out_rgb == $past(s1_low)))
    else $error("miss_pass_chk");

  // R6
  pa_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rdy |-> (s1_pa <= s1_ca))
    else $error("pa_bound_chk");

  // R10
  opaque_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy && $past(s1_hit) && ($past(s1_ca) == FULL) &&
     ($past(s1_f1code) == 3'd4) && ($past(s1_f2code) == 3'd5))
    |-> (out_rgb == $past(s1_col)))
    else $error("opaque_chk");

  // R10
  clear_ca_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy && $past(s1_hit) && ($past(s1_ca) == '0) &&
     ($past(s1_f1code) != 3'd6) && ($past(s1_f2code) != 3'd7))
    |-> (out_rgb == $past(s1_low)))
    else $error("clear_ca_chk");

endmodule

bind layer_win_blend lwb_chk #(.CW(CW)) i_lwb_chk (
  .clk       (clk),
  .rst       (rst),
  .lay_en    (lay_en),
  .low_rgb   (low_rgb),
  .out_rgb   (out_rgb),
  .s1_hit    (s1_hit),
  .s1_pa     (s1_pa),
  .s1_ca     (s1_ca),
  .s1_f1code (s1_f1code),
  .s1_f2code (s1_f2code),
  .s1_col    (s1_col),
  .s1_low    (s1_low)
);

// File: tb/test_layer_win_blend.sv
module test_layer_win_blend;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pos_x = '0;
  logic [10:0] pos_y = '0;
  logic        lay_en = 1'b0;
  logic [31:0] lay_argb = '0;
  logic [23:0] low_rgb = '0;
  logic [11:0] win_x0 = '0;
  logic [11:0] win_x1 = '0;
  logic [10:0] win_y0 = '0;
  logic [10:0] win_y1 = '0;
  logic [7:0]  const_alpha = '0;
  logic [2:0]  f1_code = '0;
  logic [2:0]  f2_code = '0;
  logic [23:0] out_rgb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // two-deep expectation pipeline
  logic [23:0] e1, e2;
  string       t1, t2;
  bit          v1 = 1'b0, v2 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_win_blend i_layer_win_blend (
    .clk, .rst, .pos_x, .pos_y, .lay_en, .lay_argb, .low_rgb,
    .win_x0, .win_x1, .win_y0, .win_y1, .const_alpha,
    .f1_code, .f2_code, .out_rgb
  );

  function automatic logic [23:0] model(
      input logic en, input logic [11:0] x, input logic [10:0] y,
      input logic [31:0] argb, input logic [23:0] low,
      input logic [11:0] x0, input logic [11:0] x1,
      input logic [10:0] y0, input logic [10:0] y1,
      input logic [7:0] ca, input logic [2:0] c1, input logic [2:0] c2);
    logic [23:0] r;
    int pa, f1, f2, v;
    if (!(en && x >= x0 && x <= x1 && y >= y0 && y <= y1)) return low;
    pa = (int'(argb[31:24]) * int'(ca) + 127) / 255;
    f1 = (c1 == 3'd6) ? pa : int'(ca);
    f2 = (c2 == 3'd7) ? 255 - pa : 255 - int'(ca);
    for (int ch = 0; ch < 3; ch++) begin
      v = (f1 * int'(argb[ch*8 +: 8]) + f2 * int'(low[ch*8 +: 8]) + 127) / 255;
      if (v > 255) v = 255;
      r[ch*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  task automatic check(input logic [23:0] got, input logic [23:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: out_rgb=%06h expected=%06h", tag, got, exp);
    end
  endtask

  task automatic apply(
      input logic en, input logic [11:0] x, input logic [10:0] y,
      input logic [31:0] argb, input logic [23:0] low,
      input logic [11:0] x0, input logic [11:0] x1,
      input logic [10:0] y0, input logic [10:0] y1,
      input logic [7:0] ca, input logic [2:0] c1, input logic [2:0] c2,
      input string tag);
    @(negedge clk);
    if (v2) check(out_rgb, e2, t2);
    e2 = e1; t2 = t1; v2 = v1;
    e1 = model(en, x, y, argb, low, x0, x1, y0, y1, ca, c1, c2);
    t1 = tag; v1 = 1'b1;
    lay_en = en; pos_x = x; pos_y = y; lay_argb = argb; low_rgb = low;
    win_x0 = x0; win_x1 = x1; win_y0 = y0; win_y1 = y1;
    const_alpha = ca; f1_code = c1; f2_code = c2;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2: run not finished, cycles=%0d expected<%0d", WATCHDOG, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // busy inputs during reset: output must still stay zero
    lay_en = 1'b1; pos_x = 12'd6; pos_y = 11'd4; lay_argb = 32'hFF_AA_BB_CC;
    low_rgb = 24'h123456; win_x0 = 12'd1; win_x1 = 12'd100; win_y0 = 11'd1;
    win_y1 = 11'd100; const_alpha = 8'hFF; f1_code = 3'd4; f2_code = 3'd5;
    repeat (4) @(negedge clk);
    check(out_rgb, 24'h0, "R1 reset");
    @(negedge clk);
    rst = 1'b0;

    // full opacity: layer colour exact
    apply(1, 12'd6, 11'd4, 32'h80_AA_BB_CC, 24'h112233, 12'd5, 12'd10, 11'd3, 11'd7,
          8'hFF, 3'd4, 3'd5, "R10 opaque");
    apply(1, 12'd6, 11'd4, 32'h80_AA_BB_CC, 24'h112233, 12'd5, 12'd10, 11'd3, 11'd7,
          8'h00, 3'd4, 3'd5, "R10 transparent");
    // saturation: F1=255, F2=255
    apply(1, 12'd6, 11'd4, 32'h00_C8_C8_10, 24'hC8_20_C8, 12'd5, 12'd10, 11'd3, 11'd7,
          8'hFF, 3'd4, 3'd7, "R8 saturate");

    // factor-code sweep over alpha grid
    for (int a = 0; a <= 255; a += 51) begin
      for (int ca = 0; ca <= 255; ca += 51) begin
        for (int c1 = 0; c1 < 8; c1++) begin
          for (int c2 = 0; c2 < 8; c2++) begin
            logic [31:0] px;
            logic [23:0] lw;
            string tg;
            px = {8'(a), 8'(a * 7 + c1 * 31), 8'(ca * 3 + c2 * 17), 8'(a + ca + 99)};
            lw = {8'(c1 * 29 + ca), 8'(255 - a), 8'(c2 * 37 + 5)};
            if ((c1 != 4 && c1 != 6) || (c2 != 5 && c2 != 7)) tg = "R9 R8 default codes";
            else tg = "R6 R7 R8 codes";
            apply(1, 12'd7, 11'd5, px, lw, 12'd5, 12'd10, 11'd3, 11'd7,
                  8'(ca), 3'(c1), 3'(c2), tg);
          end
        end
      end
    end

    // window edge walk, values change every vector (latency alignment)
    for (int y = 0; y <= 10; y++) begin
      for (int x = 0; x <= 15; x++) begin
        apply(1, 12'(x), 11'(y), {8'hC0, 8'(x * 16), 8'(y * 20), 8'hF0},
              {8'(y * 9), 8'h40, 8'(x * 3)}, 12'd5, 12'd10, 11'd3, 11'd7,
              8'hB0, 3'd6, 3'd7, "R2 R4 R5 window");
      end
    end

    // extreme bounds of counters
    apply(1, 12'hFFF, 11'h7FF, 32'hFF_01_02_03, 24'h0A0B0C, 12'h000, 12'hFFF,
          11'h000, 11'h7FF, 8'hFF, 3'd6, 3'd7, "R4 R5 max position");
    apply(1, 12'h000, 11'h000, 32'hFF_04_05_06, 24'h0A0B0C, 12'h000, 12'hFFF,
          11'h000, 11'h7FF, 8'hFF, 3'd6, 3'd7, "R4 R5 zero position");
    apply(1, 12'd11, 11'd5, 32'hFF_04_05_06, 24'h0D0E0F, 12'd5, 12'd10,
          11'd3, 11'd7, 8'hFF, 3'd4, 3'd5, "R4 just past stop");

    // layer off: nothing else matters
    for (int k = 0; k < 20; k++) begin
      apply(0, 12'd7, 11'd5, {8'(k * 13), 8'(k * 50), 8'hFF, 8'(k)},
            {8'(k * 11), 8'(k * 3), 8'(200 - k)}, 12'd5, 12'd10, 11'd3, 11'd7,
            8'(k * 12), 3'(k), 3'(k + 3), "R3 layer off");
    end

    // flush the pipeline
    apply(0, '0, '0, '0, 24'h010203, '0, '0, '0, '0, '0, 3'd4, 3'd5, "R3 flush");
    apply(0, '0, '0, '0, 24'h040506, '0, '0, '0, '0, '0, 3'd4, 3'd5, "R3 flush");
    @(negedge clk);
    if (v2) check(out_rgb, e2, t2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule